// File: doc/BRIEF.md
# In-Frame Response Start Gate

This block sits between a host register interface and the transmit path of a vehicle-bus byte-level controller. The host writes a transmit opcode as a single-cycle strobe. For a response that must be appended inside a frame that is still being received, the block decides whether the response may begin. There are two kinds of such response. The single-byte kind takes its byte from the physical-address register. The multi-byte string kind takes its bytes from the transmit-data register.

The decision uses status from the receive path: CRC verdict, length verdict, end-of-data detection, received byte count and whether a response portion is already on the bus. It also uses the block's own record of which transmit opcode is still executing. The first condition that fails decides which sticky flag is raised: CRC error, transmit aborted or data underflow. When every condition holds, a one-cycle transmit request is issued with the chosen byte.

Normal message opcodes are queued until the bus is idle. A string that runs dry for too long is closed with an underflow and a one-cycle pulse telling the transmit path to append an inverted CRC.

Top module: `ifr_start_gate`

## Requirements
- R1: Opcode codes on `op_code` are 1 message, 2 message plus CRC, 4 single-byte response, 5 string byte, 6 last string byte plus CRC; other codes are ignored. An accepted response raises `tx_req` for one cycle, starting the cycle after the strobe. Code 4 sends `phys_addr`, codes 5 and 6 send `txd_byte`, and `tx_crc` is 1 only for codes 2 and 6.
- R2: A response start with `rx_crc_ok` low sets `crc_err` (flag bit 0) and nothing else, even when later conditions also fail. No request is issued.
- R3: With `len_chk_en` high and `rx_len_ok` low, a start sets `tx_abort` (flag bit 1) and issues no request. With `len_chk_en` low, `rx_len_ok` is ignored.
- R4: A start made while `rx_eod_seen` is low raises no flag and is held. It is re-evaluated every cycle until end of data is seen, and a newer response write replaces it.
- R5: With `no_len_limit` low, a single-byte start needs `rx_byte_cnt` <= 11 and a string start needs <= 9; otherwise `tx_abort` is set. With `no_len_limit` high, the count is not checked.
- R6: A start made while a message or string is executing sets `tx_abort` and `tx_uflow` (flag bit 2). It issues a one-cycle `inv_crc_pulse` and ends that transmission.
- R7: A start made while a final-byte opcode is still executing, or while `rx_ifr_active` is high, sets `tx_abort` only.
- R8: A string byte written while a string is executing is checked only against the byte-count limit, and against the limit of two requested bytes not yet acknowledged by `tx_ack`. A failure of either sets `tx_abort`; the CRC, length and end-of-data inputs are not checked.
- R9: A message write while nothing is executing is queued, and is launched with `txd_byte` once `bus_idle` is high. A response write discards any queued message.
- R10: When a message or string is executing and every requested byte has been acknowledged, `tx_uflow` and `inv_crc_pulse` appear exactly `UFLOW_CYC` cycles after the last acknowledge, unless a further byte is requested first.
- R11: Flags stay set until a 1 is written to the matching `flag_clr` bit. A set and a clear of the same flag in the same cycle leave the flag set.
- R12: After reset all flags, `tx_req`, `tx_crc` and `inv_crc_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_wr | input | 1 | One-cycle opcode write strobe |
| op_code | input | 3 | Transmit opcode |
| txd_byte | input | DATA_W | Transmit-data register contents |
| phys_addr | input | DATA_W | Physical-address register contents |
| no_len_limit | input | 1 | 1 disables the byte-count limit |
| len_chk_en | input | 1 | 1 enables the message-length check |
| bus_idle | input | 1 | Bus free for a new message |
| rx_crc_ok | input | 1 | Received CRC valid |
| rx_len_ok | input | 1 | Received length valid |
| rx_eod_seen | input | 1 | Minimum end-of-data symbol seen |
| rx_byte_cnt | input | CNT_W | Bytes received in this frame |
| rx_ifr_active | input | 1 | A response portion is being received |
| tx_ack | input | 1 | Transmit path has sent one requested byte |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| tx_req | output | 1 | One-cycle transmit request |
| tx_byte | output | DATA_W | Byte to send with the request |
| tx_crc | output | 1 | Append CRC after this byte |
| crc_err | output | 1 | Sticky CRC error flag |
| tx_abort | output | 1 | Sticky transmit-aborted flag |
| tx_uflow | output | 1 | Sticky data-underflow flag |
| inv_crc_pulse | output | 1 | One-cycle request to append an inverted CRC |

## Verification
A host clear of a flag can fall in the same cycle as the evaluation of a request that sets that same flag. The bench clears all flags, then strobes a failing response together with the matching `flag_clr` bit, and expects the flag to read 1 afterwards. A lone clear must then read 0. Likewise, a new string byte can be evaluated while a pending start waits for end of data. The bench checks that the newer write replaces the held one and that the byte which goes out matches the newer opcode.

// File: rtl/ifrg_pkg.sv
// ifrg_pkg: shared opcode codes, evaluation verdicts and execution states
// for the in-frame response start gate. Assumes 3-bit opcodes.
package ifrg_pkg;
    localparam logic [2:0] OP_MSG      = 3'd1;
    localparam logic [2:0] OP_MSG_CRC  = 3'd2;
    localparam logic [2:0] OP_IFR2     = 3'd4;
    localparam logic [2:0] OP_IFR3     = 3'd5;
    localparam logic [2:0] OP_IFR3_CRC = 3'd6;

    localparam int NFLAG   = 3;
    localparam int FLG_CRC = 0;
    localparam int FLG_ABT = 1;
    localparam int FLG_UF  = 2;

    typedef enum logic [2:0] {
        V_GO,
        V_WAIT,
        V_CRC,
        V_ABORT,
        V_ABORT_UF
    } verdict_e;

    typedef enum logic [1:0] {
        EX_IDLE,
        EX_MSG,
        EX_IFR3,
        EX_FINAL
    } exec_e;
endpackage

// File: rtl/ifrg_cond_eval.sv
// ifrg_cond_eval: purely combinational priority evaluator for a response
// request. Walks the start conditions in fixed order and reports the first
// failure; a string continuation is checked only against byte count and room.
// Assumes the caller presents a response opcode (single byte or string).
module ifrg_cond_eval
    import ifrg_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int IFR2_MAX = 11,
    parameter int IFR3_MAX = 9
) (
    input  logic [2:0]       op,
    input  logic             is_cont,
    input  logic             cont_full,
    input  logic             crc_ok,
    input  logic             len_chk_en,
    input  logic             len_ok,
    input  logic             eod_seen,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             no_len_limit,
    input  exec_e            exec_st,
    input  logic             rx_ifr_active,
    output verdict_e         verdict
);
    localparam logic [CNT_W-1:0] LIM2 = CNT_W'(IFR2_MAX);
    localparam logic [CNT_W-1:0] LIM3 = CNT_W'(IFR3_MAX);

    logic [CNT_W-1:0] limit;
    logic             cnt_bad;

    // Pick the byte-count ceiling for this opcode and test it.
    always_comb begin
        limit   = (op == OP_IFR2) ? LIM2 : LIM3;
        cnt_bad = !no_len_limit && (byte_cnt > limit);
    end

    // Ordered condition walk; the first failing check decides the verdict.
    always_comb begin
        verdict = V_GO;
        if (is_cont) begin
            if (cnt_bad || cont_full) verdict = V_ABORT;
        end else if (!crc_ok) begin
            verdict = V_CRC;
        end else if (len_chk_en && !len_ok) begin
            verdict = V_ABORT;
        end else if (!eod_seen) begin
            verdict = V_WAIT;
        end else if (cnt_bad) begin
            verdict = V_ABORT;
        end else if (exec_st == EX_MSG || exec_st == EX_IFR3) begin
            verdict = V_ABORT_UF;
        end else if (exec_st == EX_FINAL) begin
            verdict = V_ABORT;
        end else if (rx_ifr_active) begin
            verdict = V_ABORT;
        end
    end

    // A fresh start may only be granted with a good CRC and end of data seen.
    always_comb begin
        if (verdict == V_GO && !is_cont) begin
            a_go_needs_crc_r2: assert (crc_ok && eod_seen)
                else $error("start granted without CRC/EOD");
        end
    end
endmodule

// File: rtl/ifrg_uflow_timer.sv
// ifrg_uflow_timer: counts cycles while a string is starved of data and
// reports expiry after UFLOW_CYC such cycles. Restarts whenever run drops.
module ifrg_uflow_timer #(
    parameter int UFLOW_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int TW = $clog2(UFLOW_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(UFLOW_CYC - 1);

    logic [TW-1:0] cnt_q;

    // Starvation counter: advances while run is high, clears otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (!run)                cnt_q <= '0;
        else if (cnt_q != LAST)       cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == LAST);

    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    p_count_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/ifrg_flag_bank.sv
// ifrg_flag_bank: sticky status flags with write-one-to-clear; a set in the
// same cycle as a clear wins. One identical cell per flag.
module ifrg_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        // One sticky cell: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end

        p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
            flags[i] && !clr[i] |=> flags[i]);
        p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
    end
endmodule

// File: rtl/ifr_start_gate.sv
// ifr_start_gate: top of the in-frame response start gate. Accepts opcode
// strobes, queues normal messages until the bus is idle, evaluates response
// starts and string continuations, tracks what is executing and how many
// requested bytes are unacknowledged (at most two), and raises sticky flags.
// Assumes tx_ack pulses once per requested byte sent by the transmit path.
module ifr_start_gate
    import ifrg_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 5,
    parameter int IFR2_MAX  = 11,
    parameter int IFR3_MAX  = 9,
    parameter int UFLOW_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_wr,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] txd_byte,
    input  logic [DATA_W-1:0] phys_addr,
    input  logic              no_len_limit,
    input  logic              len_chk_en,
    input  logic              bus_idle,
    input  logic              rx_crc_ok,
    input  logic              rx_len_ok,
    input  logic              rx_eod_seen,
    input  logic [CNT_W-1:0]  rx_byte_cnt,
    input  logic              rx_ifr_active,
    input  logic              tx_ack,
    input  logic [2:0]        flag_clr,
    output logic              tx_req,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_crc,
    output logic              crc_err,
    output logic              tx_abort,
    output logic              tx_uflow,
    output logic              inv_crc_pulse
);
    localparam logic [1:0] OUT_MAX = 2'd2;

    exec_e             exec_q, exec_d;
    logic [1:0]        outst_q, outst_d;
    logic              pend_v_q;
    logic [2:0]        pend_op_q;
    logic              msg_q, msg_crc_q;
    logic              req_q;
    logic [DATA_W-1:0] byte_q;
    logic              crc_q;
    logic              pulse_q;

    logic              wr_ifr, wr_msg, ev_valid, ev_cont, cont_full;
    logic [2:0]        ev_op;
    verdict_e          verdict;
    logic              ifr_go, abort_uf, msg_cont, msg_cont_go, msg_cont_ovf;
    logic              msg_launch, issue, tmr_run, tmr_exp, expire_eff, dec;
    logic [NFLAG-1:0]  flag_set, flag_q;
    logic [DATA_W-1:0] byte_d;
    logic              crc_d;

    // Classify the strobe and pick the request under evaluation.
    always_comb begin
        wr_ifr    = op_wr && (op_code == OP_IFR2 || op_code == OP_IFR3 ||
                              op_code == OP_IFR3_CRC);
        wr_msg    = op_wr && (op_code == OP_MSG || op_code == OP_MSG_CRC);
        ev_valid  = wr_ifr || pend_v_q;
        ev_op     = wr_ifr ? op_code : pend_op_q;
        ev_cont   = (exec_q == EX_IFR3) && (ev_op != OP_IFR2);
        cont_full = (outst_q == OUT_MAX);
    end

    ifrg_cond_eval #(
        .CNT_W    (CNT_W),
        .IFR2_MAX (IFR2_MAX),
        .IFR3_MAX (IFR3_MAX)
    ) u_eval (
        .op            (ev_op),
        .is_cont       (ev_cont),
        .cont_full     (cont_full),
        .crc_ok        (rx_crc_ok),
        .len_chk_en    (len_chk_en),
        .len_ok        (rx_len_ok),
        .eod_seen      (rx_eod_seen),
        .byte_cnt      (rx_byte_cnt),
        .no_len_limit  (no_len_limit),
        .exec_st       (exec_q),
        .rx_ifr_active (rx_ifr_active),
        .verdict       (verdict)
    );

    ifrg_uflow_timer #(
        .UFLOW_CYC (UFLOW_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .expire (tmr_exp)
    );

    // Derive the per-cycle actions: grants, message paths, timer, flag sets.
    always_comb begin
        ifr_go       = ev_valid && (verdict == V_GO);
        abort_uf     = ev_valid && (verdict == V_ABORT_UF);
        msg_cont     = wr_msg && (exec_q == EX_MSG) && !abort_uf;
        msg_cont_go  = msg_cont && !cont_full;
        msg_cont_ovf = msg_cont && cont_full;
        msg_launch   = msg_q && bus_idle && (exec_q == EX_IDLE) && !ev_valid;
        issue        = ifr_go || msg_cont_go || msg_launch;
        tmr_run      = (exec_q == EX_MSG || exec_q == EX_IFR3) && (outst_q == 2'd0);
        expire_eff   = tmr_exp && !issue;
        dec          = tx_ack && (outst_q != 2'd0);

        flag_set          = '0;
        flag_set[FLG_CRC] = ev_valid && (verdict == V_CRC);
        flag_set[FLG_ABT] = (ev_valid && (verdict == V_ABORT || verdict == V_ABORT_UF))
                            || msg_cont_ovf;
        flag_set[FLG_UF]  = abort_uf || expire_eff;
    end

    // Select the byte and CRC-append marker for whichever path issues.
    always_comb begin
        byte_d = txd_byte;
        crc_d  = 1'b0;
        if (ifr_go) begin
            byte_d = (ev_op == OP_IFR2) ? phys_addr : txd_byte;
            crc_d  = (ev_op == OP_IFR3_CRC);
        end else if (msg_cont_go) begin
            crc_d  = (op_code == OP_MSG_CRC);
        end else if (msg_launch) begin
            crc_d  = msg_crc_q;
        end
    end

    // Next execution state and unacknowledged-byte count.
    always_comb begin
        outst_d = outst_q + {1'b0, issue} - {1'b0, dec};
        exec_d  = exec_q;
        if (abort_uf || expire_eff) begin
            exec_d  = EX_IDLE;
            outst_d = 2'd0;
        end else if (ifr_go) begin
            exec_d = (ev_op == OP_IFR3) ? EX_IFR3 : EX_FINAL;
        end else if (msg_cont_go) begin
            exec_d = (op_code == OP_MSG_CRC) ? EX_FINAL : EX_MSG;
        end else if (msg_launch) begin
            exec_d = msg_crc_q ? EX_FINAL : EX_MSG;
        end else if (exec_q == EX_FINAL && outst_d == 2'd0) begin
            exec_d = EX_IDLE;
        end
    end

    // Execution tracking registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_q  <= EX_IDLE;
            outst_q <= 2'd0;
        end else begin
            exec_q  <= exec_d;
            outst_q <= outst_d;
        end
    end

    // Held response start, waiting for end of data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v_q  <= 1'b0;
            pend_op_q <= 3'd0;
        end else if (ev_valid) begin
            pend_v_q  <= (verdict == V_WAIT);
            pend_op_q <= ev_op;
        end
    end

    // Normal-message queue; a response write discards it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_q     <= 1'b0;
            msg_crc_q <= 1'b0;
        end else if (wr_ifr) begin
            msg_q     <= 1'b0;
        end else if (wr_msg && exec_q != EX_MSG) begin
            msg_q     <= 1'b1;
            msg_crc_q <= (op_code == OP_MSG_CRC);
        end else if (msg_launch) begin
            msg_q     <= 1'b0;
        end
    end

    // Registered transmit request and inverted-CRC pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            byte_q  <= '0;
            crc_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            req_q   <= issue;
            pulse_q <= flag_set[FLG_UF];
            if (issue) begin
                byte_q <= byte_d;
                crc_q  <= crc_d;
            end else begin
                crc_q  <= 1'b0;
            end
        end
    end

    ifrg_flag_bank #(
        .N (NFLAG)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flag_q)
    );

    assign tx_req        = req_q;
    assign tx_byte       = byte_q;
    assign tx_crc        = crc_q;
    assign inv_crc_pulse = pulse_q;
    assign crc_err       = flag_q[FLG_CRC];
    assign tx_abort      = flag_q[FLG_ABT];
    assign tx_uflow      = flag_q[FLG_UF];

    p_out_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q <= OUT_MAX);
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_crc_pulse |=> !inv_crc_pulse);
    p_pulse_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_crc_pulse |-> tx_uflow);
    p_crc_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> !tx_req);
    p_pulse_idles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_crc_pulse |-> exec_q == EX_IDLE);
endmodule

// File: tb/ifr_start_gate_test.sv
// Bench for ifr_start_gate: a vector table of start conditions, then
// directed tests for reset, waiting, execution conflicts, strings,
// underflow timing, the message queue and flag clearing.
module ifr_start_gate_test;
    localparam int CLK_PERIOD = 10;
    localparam int UF_N       = 8;
    localparam logic [7:0] PA = 8'hA5;
    localparam logic [7:0] TD = 8'h3C;

    typedef struct packed {
        logic       crc_ok;
        logic       len_en;
        logic       len_ok;
        logic       nfl;
        logic       rxifr;
        logic [4:0] cnt;
        logic [2:0] op;
        logic       e_req;
        logic       e_crc;
        logic       e_ab;
        logic       e_uf;
    } vec_t;

    localparam int NV = 11;
    localparam logic [16:0] TBL [NV] = '{
        {5'b10000, 5'd11, 3'd4, 4'b1000},  // R1 R5 single byte at limit
        {5'b10000, 5'd12, 3'd4, 4'b0010},  // R5 over limit
        {5'b10010, 5'd31, 3'd4, 4'b1000},  // R5 limit disabled
        {5'b10000, 5'd9,  3'd5, 4'b1000},  // R1 R5 string at limit
        {5'b10000, 5'd10, 3'd5, 4'b0010},  // R5 string over limit
        {5'b00000, 5'd12, 3'd4, 4'b0100},  // R2 CRC outranks count
        {5'b11000, 5'd3,  3'd4, 4'b0010},  // R3 length bad
        {5'b10000, 5'd3,  3'd5, 4'b1000},  // R3 length ignored
        {5'b10001, 5'd3,  3'd4, 4'b0010},  // R7 response portion on bus
        {5'b01001, 5'd3,  3'd6, 4'b0100},  // R2 CRC outranks all
        {5'b10000, 5'd9,  3'd6, 4'b1000}   // R1 last string byte
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_wr = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic       no_len_limit = 1'b0, len_chk_en = 1'b0, bus_idle = 1'b0;
    logic       rx_crc_ok = 1'b1, rx_len_ok = 1'b1, rx_eod_seen = 1'b1;
    logic [4:0] rx_byte_cnt = 5'd0;
    logic       rx_ifr_active = 1'b0, tx_ack = 1'b0;
    logic [2:0] flag_clr = 3'd0;
    logic       tx_req, tx_crc, crc_err, tx_abort, tx_uflow, inv_crc_pulse;
    logic [7:0] tx_byte;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    ifr_start_gate #(.UFLOW_CYC(UF_N)) uut (
        .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_code(op_code),
        .txd_byte(TD), .phys_addr(PA), .no_len_limit(no_len_limit),
        .len_chk_en(len_chk_en), .bus_idle(bus_idle), .rx_crc_ok(rx_crc_ok),
        .rx_len_ok(rx_len_ok), .rx_eod_seen(rx_eod_seen),
        .rx_byte_cnt(rx_byte_cnt), .rx_ifr_active(rx_ifr_active),
        .tx_ack(tx_ack), .flag_clr(flag_clr), .tx_req(tx_req),
        .tx_byte(tx_byte), .tx_crc(tx_crc), .crc_err(crc_err),
        .tx_abort(tx_abort), .tx_uflow(tx_uflow), .inv_crc_pulse(inv_crc_pulse)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; op_wr = 1'b0; tx_ack = 1'b0; flag_clr = 3'd0; bus_idle = 1'b0;
        rx_crc_ok = 1'b1; len_chk_en = 1'b0; rx_len_ok = 1'b1; rx_eod_seen = 1'b1;
        no_len_limit = 1'b0; rx_ifr_active = 1'b0; rx_byte_cnt = 5'd3;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic strobe(input logic [2:0] op);
        op_wr = 1'b1; op_code = op;
        tick();
        op_wr = 1'b0;
    endtask

    task automatic ack();
        tx_ack = 1'b1;
        tick();
        tx_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R12 reset state
        check("R12 flags", {crc_err, tx_abort, tx_uflow}, 3'b000);
        check("R12 req", {tx_req, tx_crc, inv_crc_pulse}, 3'b000);

        // Table of start conditions from an idle block.
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(TBL[i]);
            do_reset();
            rx_crc_ok = v.crc_ok; len_chk_en = v.len_en; rx_len_ok = v.len_ok;
            no_len_limit = v.nfl; rx_ifr_active = v.rxifr; rx_byte_cnt = v.cnt;
            strobe(v.op);
            check($sformatf("R1/R2/R3/R5/R7 vec%0d req", i), tx_req, v.e_req);
            check($sformatf("R2 vec%0d crc_err", i), crc_err, v.e_crc);
            check($sformatf("R3/R5/R7 vec%0d abort", i), tx_abort, v.e_ab);
            check($sformatf("R6 vec%0d uflow", i), tx_uflow, v.e_uf);
            if (v.e_req) begin
                check($sformatf("R1 vec%0d byte", i), tx_byte, (v.op == 3'd4) ? PA : TD);
                check($sformatf("R1 vec%0d crc mark", i), tx_crc, v.op == 3'd6);
            end
        end

        // R4 hold until end of data, newer write replaces held one.
        do_reset();
        rx_eod_seen = 1'b0;
        strobe(3'd4);
        check("R4 held no req", tx_req, 1'b0);
        check("R4 held no flag", {crc_err, tx_abort, tx_uflow}, 3'b000);
        strobe(3'd5);
        check("R4 still held", tx_req, 1'b0);
        rx_eod_seen = 1'b1;
        tick();
        check("R4 released req", tx_req, 1'b1);
        check("R4 newer byte", tx_byte, TD);

        // R6 single-byte start during an executing string.
        do_reset();
        strobe(3'd5);
        check("R6 string started", tx_req, 1'b1);
        strobe(3'd4);
        check("R6 abort", tx_abort, 1'b1);
        check("R6 uflow", tx_uflow, 1'b1);
        check("R6 pulse", inv_crc_pulse, 1'b1);
        check("R6 no req", tx_req, 1'b0);
        tick();
        check("R6 pulse one cycle", inv_crc_pulse, 1'b0);

        // R7 start during a final-byte opcode still executing.
        do_reset();
        strobe(3'd4);
        strobe(3'd4);
        check("R7 abort", tx_abort, 1'b1);
        check("R7 no uflow", tx_uflow, 1'b0);

        // R8 continuation: count checked, CRC not checked.
        do_reset();
        rx_byte_cnt = 5'd9;
        strobe(3'd5);
        ack();
        rx_byte_cnt = 5'd12;
        strobe(3'd5);
        check("R8 cont over count", tx_abort, 1'b1);
        check("R8 cont no req", tx_req, 1'b0);
        rx_byte_cnt = 5'd8; rx_crc_ok = 1'b0; rx_eod_seen = 1'b0;
        strobe(3'd6);
        check("R8 cont granted", tx_req, 1'b1);
        check("R8 cont crc mark", tx_crc, 1'b1);
        check("R8 cont no crc flag", crc_err, 1'b0);

        // R8 at most two unacknowledged bytes.
        do_reset();
        strobe(3'd5);
        strobe(3'd5);
        check("R8 second byte", tx_req, 1'b1);
        strobe(3'd5);
        check("R8 room abort", tx_abort, 1'b1);
        check("R8 room no req", tx_req, 1'b0);

        // R10 underflow exactly UF_N cycles after the last acknowledge.
        do_reset();
        strobe(3'd5);
        tx_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_ack = 1'b0;
        begin
            int k;
            k = 0;
            while (!inv_crc_pulse && k < 4 * UF_N) begin
                tick();
                k++;
            end
            check("R10 underflow delay", k, UF_N);
            check("R10 uflow flag", tx_uflow, 1'b1);
        end

        // R9 queued message launches when idle.
        do_reset();
        bus_idle = 1'b1;
        strobe(3'd2);
        check("R9 queued not yet", tx_req, 1'b0);
        tick();
        check("R9 launch", tx_req, 1'b1);
        check("R9 launch byte", tx_byte, TD);
        check("R9 launch crc", tx_crc, 1'b1);

        // R9 response write discards queued message.
        do_reset();
        strobe(3'd1);
        strobe(3'd4);
        check("R9 response byte", tx_byte, PA);
        ack();
        bus_idle = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int j = 0; j < 5; j++) begin
                tick();
                if (tx_req) seen++;
            end
            check("R9 queue discarded", seen, 0);
        end

        // R11 set and clear same cycle; then a lone clear.
        do_reset();
        rx_byte_cnt = 5'd20;
        flag_clr = 3'b010;
        strobe(3'd4);
        flag_clr = 3'b000;
        check("R11 set wins", tx_abort, 1'b1);
        tick();
        check("R11 sticky", tx_abort, 1'b1);
        flag_clr = 3'b010;
        tick();
        flag_clr = 3'b000;
        check("R11 cleared", tx_abort, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule